// File: doc/BRIEF.md
# HDLC Frame Status Queue with Byte Counter

This block sits on the receive side of a bit-oriented (HDLC/SDLC) serial channel. It counts the bytes of each incoming frame. When the frame ends, it stores that count, together with the frame's residue, overrun and CRC-error status, as one entry in a ten-deep queue. Software can then let several frames arrive back to back and collect their lengths and status afterwards, without servicing each frame as it closes.

Software reads the queue through three register views. It reads the count-high view first. This read reports whether data is available and whether the queue has overflowed, and it latches whether the following main-status read comes from the queue or from the live status. It then reads the count-low view, which is optional, and finally the main-status view. The main-status read removes exactly one entry. The queue is only in use when the enable control is set and the channel is in HDLC mode. Otherwise every view passes the live registers straight through, so existing software keeps working.

Top module: `hdlc_frame_status_fifo`

## Requirements
- R1: When `fifo_en` is 0 or `hdlc_mode` is 0, the block bypasses the queue. `main_stat` equals `live_main`, `cnt_lo` equals `live_aux2` and `cnt_hi` equals `live_aux3`. An end of frame stores nothing, so `data_avail` stays 0.
- R2: After `rst_n` is held low, or after `chan_rst` is asserted, the queue is empty and `data_avail` and `fifo_ovf` are both 0.
- R3: The 14-bit byte counter clears on `open_flag` and adds one on each `byte_stb`. It wraps modulo 16384, and it clears again after every `eof`.
- R4: An `eof` while the queue is active stores the current count with `frm_residue`, `frm_overrun` and `frm_crc_err`. Entries come out in arrival order.
- R5: The queue holds 10 entries. An `eof` while it is full discards the new entry, keeps the stored ones and sets `fifo_ovf`.
- R6: `fifo_ovf` is sticky. Only a reset, or dropping and restoring the enable (which also empties the queue), clears it.
- R7: While the queue is active, `cnt_hi` = {overflow, data available, count[13:8]} (bit 7, bit 6, bits 5:0), and `cnt_lo` = count[7:0] of the head entry.
- R8: Main status layout: bit 0 all-sent, bits 3:1 residue, bit 4 parity, bit 5 overrun, bit 6 CRC error, bit 7 end of frame. A `rd_cnt_hi` pulse taken while the queue is non-empty steers bits 6, 5 and 3:1 to the head entry, while bits 7, 4 and 0 stay live. A `rd_cnt_hi` pulse taken while the queue is empty leaves all of `main_stat` live.
- R9: After steering, one `rd_main` pulse removes exactly one entry and returns `main_stat` to live. Further `rd_main` pulses remove nothing until the next `rd_cnt_hi`.
- R10: A `rd_main` pulse with the queue empty, or without a preceding steering read, does not alter the queue contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| chan_rst | input | 1 | Synchronous channel reset, active high |
| fifo_en | input | 1 | Queue enable control bit |
| hdlc_mode | input | 1 | Channel is in HDLC/SDLC mode |
| open_flag | input | 1 | Opening flag of a frame seen |
| byte_stb | input | 1 | One received byte |
| eof | input | 1 | End of frame |
| frm_residue | input | 3 | Residue bits of the ending frame |
| frm_overrun | input | 1 | Overrun status of the ending frame |
| frm_crc_err | input | 1 | CRC error of the ending frame |
| live_main | input | 8 | Live main status register |
| live_aux2 | input | 8 | Live basic register imaged by the count-low view |
| live_aux3 | input | 8 | Live basic register imaged by the count-high view |
| rd_main | input | 1 | Read strobe of the main status view |
| rd_cnt_hi | input | 1 | Read strobe of the count-high view |
| main_stat | output | 8 | Main status view |
| cnt_lo | output | 8 | Count-low view |
| cnt_hi | output | 8 | Count-high view |
| data_avail | output | 1 | Queue is not empty |
| fifo_ovf | output | 1 | Sticky queue overflow |

## Verification
The bench repeats main-status reads after a steered read. A design without the pop-once guard would discard the following frame's entry, and the next count read would then show the wrong length. It also reads main status while the queue is empty, which would corrupt the pointers in a design without underflow protection. It writes eleven frames to expose an overflow that overwrote old entries or that cleared itself once the queue drained, and it toggles the enable to confirm that this is what clears the flag. A 16385-byte frame and a 300-byte frame probe the counter's wrap and the placement of the high count bits, and bypass checks catch a queue that records frames while it is disabled or outside HDLC mode.

// File: rtl/fsf_pkg.sv
`timescale 1ns/1ps
// Shared constants and the queue entry type for the frame status queue.
package fsf_pkg;
    localparam int unsigned FSF_CNT_W = 14;
    localparam int unsigned FSF_RES_W = 3;

    typedef struct packed {
        logic [FSF_CNT_W-1:0] count;
        logic [FSF_RES_W-1:0] residue;
        logic                 overrun;
        logic                 crc_err;
    } fsf_entry_t;
endpackage

// File: rtl/fsf_byte_counter.sv
`timescale 1ns/1ps
// Frame byte counter.
// Clears on the opening flag and at end of frame, and counts byte strobes.
// Assumes open_flag, eof and byte_stb are single-cycle pulses. The counter
// wraps at its width.
module fsf_byte_counter #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             open_flag,
    input  logic             byte_stb,
    input  logic             eof,
    output logic [CNT_W-1:0] count
);
    // Count bytes between the opening flag and the end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (open_flag || eof) begin
            count <= '0;
        end else if (byte_stb) begin
            count <= count + 1'b1;
        end
    end

    // R3
    byte_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !open_flag && !eof && !clr) |=> count == $past(count) + 1'b1);

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_flag || eof) |=> count == '0);
endmodule

// File: rtl/fsf_entry_fifo.sv
`timescale 1ns/1ps
// Circular queue of frame status entries.
// Drops a push while full and then raises a sticky overflow, which only flush
// clears. Flush also resets both pointers. Assumes the caller never pops
// while empty, and ignores such a pop if it happens.
module fsf_entry_fifo
    import fsf_pkg::*;
#(
    parameter int unsigned DEPTH = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       push,
    input  fsf_entry_t wdata,
    input  logic       pop,
    output fsf_entry_t rdata,
    output logic       empty,
    output logic       full,
    output logic       overflow
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    fsf_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [OCC_W-1:0] occ;
    logic             push_ok, pop_ok;

    assign empty   = (occ == '0);
    assign full    = (occ == FULL_OCC);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Write the storage array. It has no reset, because the pointers guard it.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                occ <= occ + 1'b1;
            end else if (pop_ok && !push_ok) begin
                occ <= occ - 1'b1;
            end
        end
    end

    // Set the sticky overflow flag on a push into a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            overflow <= 1'b0;
        end else if (push && full) begin
            overflow <= 1'b1;
        end
    end

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && wr_ptr == $past(wr_ptr)));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R5
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC);
endmodule

// File: rtl/fsf_read_steer.sv
`timescale 1ns/1ps
// Read steering for the main status view.
// A count-high read latches whether the queue held data. The next main read
// pops once and drops the steering. Assumes the two read strobes never
// coincide.
module fsf_read_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic rd_hi,
    input  logic rd_main,
    input  logic empty,
    output logic steer,
    output logic pop
);
    assign pop = rd_main && steer;

    // Latch the steering on a count-high read and release it on a main read.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            steer <= 1'b0;
        end else if (rd_hi) begin
            steer <= !empty;
        end else if (rd_main) begin
            steer <= 1'b0;
        end
    end

    // R9
    pop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !rd_hi) |=> !pop);

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steer |-> !empty);
endmodule

// File: rtl/hdlc_frame_status_fifo.sv
`timescale 1ns/1ps
// Receive frame status queue with byte counter.
// At end of frame it queues the byte count and frame status while the
// enable bit is set and the channel is in HDLC mode. Otherwise every view
// bypasses to the live registers. Assumes the strobes are single-cycle pulses.
module hdlc_frame_status_fifo
    import fsf_pkg::*;
#(
    parameter int unsigned DEPTH = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_rst,
    input  logic       fifo_en,
    input  logic       hdlc_mode,
    input  logic       open_flag,
    input  logic       byte_stb,
    input  logic       eof,
    input  logic [2:0] frm_residue,
    input  logic       frm_overrun,
    input  logic       frm_crc_err,
    input  logic [7:0] live_main,
    input  logic [7:0] live_aux2,
    input  logic [7:0] live_aux3,
    input  logic       rd_main,
    input  logic       rd_cnt_hi,
    output logic [7:0] main_stat,
    output logic [7:0] cnt_lo,
    output logic [7:0] cnt_hi,
    output logic       data_avail,
    output logic       fifo_ovf
);
    localparam int unsigned HI_W = FSF_CNT_W - 8;

    logic                 active, flush, push, pop, steer, empty, full, ovf;
    logic [FSF_CNT_W-1:0] count;
    fsf_entry_t           wentry, head;

    assign active = fifo_en && hdlc_mode;
    assign flush  = chan_rst || !active;
    assign push   = eof && active;
    assign wentry = '{count: count, residue: frm_residue,
                      overrun: frm_overrun, crc_err: frm_crc_err};

    fsf_byte_counter #(.CNT_W(FSF_CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (chan_rst),
        .open_flag (open_flag),
        .byte_stb  (byte_stb),
        .eof       (eof),
        .count     (count)
    );

    fsf_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push     (push),
        .wdata    (wentry),
        .pop      (pop),
        .rdata    (head),
        .empty    (empty),
        .full     (full),
        .overflow (ovf)
    );

    fsf_read_steer u_steer (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .rd_hi   (rd_cnt_hi),
        .rd_main (rd_main),
        .empty   (empty),
        .steer   (steer),
        .pop     (pop)
    );

    assign data_avail = !empty;
    assign fifo_ovf   = ovf;

    // Select the register views: queue fields when active, live images otherwise.
    always_comb begin
        if (active) begin
            cnt_hi = {ovf, !empty, head.count[FSF_CNT_W-1 -: HI_W]};
            cnt_lo = head.count[7:0];
        end else begin
            cnt_hi = live_aux3;
            cnt_lo = live_aux2;
        end
        if (active && steer) begin
            main_stat = {live_main[7], head.crc_err, head.overrun, live_main[4],
                         head.residue, live_main[0]};
        end else begin
            main_stat = live_main;
        end
    end

    // R1
    bypass_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !data_avail && !fifo_ovf);

    // R2
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> !data_avail && !fifo_ovf);

    // R4
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !chan_rst) |=> data_avail);
endmodule

// File: tb/hdlc_frame_status_fifo_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the frame driver queues the expected entries, and the
// read monitor takes them off the queue and compares them with the views.
module hdlc_frame_status_fifo_tb;
    logic       clk = 0, rst_n = 0, chan_rst = 0, fifo_en = 0, hdlc_mode = 0;
    logic       open_flag = 0, byte_stb = 0, eof = 0;
    logic [2:0] frm_residue = 0;
    logic       frm_overrun = 0, frm_crc_err = 0;
    logic [7:0] live_main = 8'hF1, live_aux2 = 8'h5A, live_aux3 = 8'hC3;
    logic       rd_main = 0, rd_cnt_hi = 0;
    logic [7:0] main_stat, cnt_lo, cnt_hi;
    logic       data_avail, fifo_ovf;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [18:0] sb[$];   // {count[13:0], residue, overrun, crc}
    bit model_ovf = 0;

    always #4 clk = ~clk;

    hdlc_frame_status_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .fifo_en(fifo_en),
        .hdlc_mode(hdlc_mode), .open_flag(open_flag), .byte_stb(byte_stb),
        .eof(eof), .frm_residue(frm_residue), .frm_overrun(frm_overrun),
        .frm_crc_err(frm_crc_err), .live_main(live_main), .live_aux2(live_aux2),
        .live_aux3(live_aux3), .rd_main(rd_main), .rd_cnt_hi(rd_cnt_hi),
        .main_stat(main_stat), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .data_avail(data_avail), .fifo_ovf(fifo_ovf)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: sends one frame and records what the queue should hold.
    task automatic send_frame(input int n, input logic [2:0] res,
                              input logic ovr, input logic crc);
        @(negedge clk) open_flag = 1;
        @(negedge clk) open_flag = 0;
        for (int i = 0; i < n; i++) begin
            byte_stb = 1;
            @(negedge clk);
        end
        byte_stb = 0;
        frm_residue = res; frm_overrun = ovr; frm_crc_err = crc; eof = 1;
        @(negedge clk) eof = 0;
        if (fifo_en && hdlc_mode) begin
            if (sb.size() < 10) sb.push_back({14'(n), res, ovr, crc});
            else model_ovf = 1;
        end
    endtask

    // Monitor: runs the full read sequence and compares the results with the scoreboard.
    task automatic read_entry(input string req);
        logic [18:0] e;
        e = (sb.size() != 0) ? sb[0] : '0;
        @(negedge clk) rd_cnt_hi = 1;
        #1;
        check(req, "R7 cnt_hi flags", {30'd0, cnt_hi[7:6]}, {30'd0, model_ovf, sb.size() != 0});
        if (sb.size() != 0) check(req, "R7 cnt_hi count", {26'd0, cnt_hi[5:0]}, {26'd0, e[18:13]});
        @(negedge clk) rd_cnt_hi = 0;
        #1;
        if (sb.size() != 0) begin
            check(req, "R7 cnt_lo", {24'd0, cnt_lo}, {24'd0, e[12:5]});
            check(req, "R8 main steered", {24'd0, main_stat},
                  {24'd0, live_main[7], e[0], e[1], live_main[4], e[4:2], live_main[0]});
        end else begin
            check(req, "R8 main live when empty", {24'd0, main_stat}, {24'd0, live_main});
        end
        @(negedge clk) rd_main = 1;
        @(negedge clk) rd_main = 0;
        #1;
        check(req, "R9 main live after pop", {24'd0, main_stat}, {24'd0, live_main});
        if (sb.size() != 0) void'(sb.pop_front());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R2 reset state, R1 bypass images
        check("R2", "avail after reset", {31'd0, data_avail}, 0);
        check("R2", "ovf after reset", {31'd0, fifo_ovf}, 0);
        check("R1", "cnt_hi image", {24'd0, cnt_hi}, {24'd0, live_aux3});
        check("R1", "cnt_lo image", {24'd0, cnt_lo}, {24'd0, live_aux2});
        check("R1", "main image", {24'd0, main_stat}, {24'd0, live_main});

        // R1: a frame with the queue disabled, then one outside HDLC mode
        hdlc_mode = 1;
        send_frame(4, 3'b001, 1, 0);
        check("R1", "no store when disabled", {31'd0, data_avail}, 0);
        hdlc_mode = 0; fifo_en = 1;
        send_frame(4, 3'b001, 1, 0);
        check("R1", "no store outside hdlc", {31'd0, data_avail}, 0);
        check("R1", "main image non-hdlc", {24'd0, main_stat}, {24'd0, live_main});
        hdlc_mode = 1;
        @(negedge clk);

        // R3 R4 R7 R8: three frames of different sizes and status, read in order
        send_frame(3, 3'b101, 0, 0);
        send_frame(300, 3'b010, 1, 1);
        send_frame(1, 3'b111, 0, 1);
        #1 check("R4", "avail after frames", {31'd0, data_avail}, 1);
        read_entry("R4");
        // R9: repeated main reads must not pop a second entry
        @(negedge clk) rd_main = 1;
        @(negedge clk) rd_main = 0;
        @(negedge clk) rd_main = 1;
        @(negedge clk) rd_main = 0;
        read_entry("R9");
        read_entry("R3");

        // R10: main reads while empty, then an empty steer read, then normal use
        @(negedge clk) rd_main = 1;
        @(negedge clk) rd_main = 0;
        read_entry("R10");
        send_frame(7, 3'b011, 1, 0);
        read_entry("R10");
        #1 check("R10", "empty after one frame", {31'd0, data_avail}, 0);

        // R5 R6: eleven frames overflow a ten-entry queue
        for (int f = 0; f < 11; f++) send_frame(f + 2, 3'(f), f[0], f[1]);
        #1 check("R5", "ovf set", {31'd0, fifo_ovf}, 1);
        for (int f = 0; f < 10; f++) read_entry("R5");
        #1 check("R6", "ovf sticky when drained", {31'd0, fifo_ovf}, 1);
        @(negedge clk) fifo_en = 0;
        @(negedge clk) fifo_en = 1;
        model_ovf = 0;
        #1 check("R6", "ovf cleared by enable toggle", {31'd0, fifo_ovf}, 0);

        // R6: disabling empties the queue
        send_frame(5, 3'b000, 0, 0);
        @(negedge clk) fifo_en = 0;
        @(negedge clk) fifo_en = 1;
        sb.delete();
        #1 check("R6", "disable flushes", {31'd0, data_avail}, 0);

        // R2: a channel reset clears entries
        send_frame(5, 3'b000, 0, 0);
        @(negedge clk) chan_rst = 1;
        @(negedge clk) chan_rst = 0;
        sb.delete();
        #1 check("R2", "chan_rst flushes", {31'd0, data_avail}, 0);

        // R3: the 14-bit counter wraps; 16385 bytes give a count of 1
        send_frame(16385, 3'b110, 0, 1);
        read_entry("R3");

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule